// File: doc/BRIEF.md
# Checkpoint Value Move Sequencer

This block repairs a mispredicted single-use register reuse. A physical register (the source) was handed to a new producer while its older value still lives in the register's shadow checkpoint cell. Once a further consumer of that older value turns up, the value has to move to a fresh physical register (the destination). The sequencer accepts one move request at a time. The request carries the source tag, the destination tag and a flag that says whether the instruction writing the source has already executed. From these the sequencer drives the register file's read, restore and write ports.

When the flag is set, the sequencer runs a swap. It parks the current main value of the source in an auxiliary register. It then restores the checkpoint into the main cell and reads it into a second auxiliary register. Finally it writes the checkpoint to the destination and the parked value back to the source. When the flag is clear, the checkpoint was never taken, so the sequencer only copies the source to the destination.

During a swap the source register is not coherent in the array. For that window the sequencer offers a forwarding port: reads of the source are answered from the first auxiliary register, and writes to the source are absorbed into it. The register file is assumed to return read data one cycle after a read request, and to read the old contents when a read and a write to the same cell fall in the same cycle.

Top module: `ckpt_move_seq`

## Requirements
- R1: With the executed flag at 1, the move ends with the destination holding the source's checkpoint value and the source holding its pre-move main value. The restore port pulses exactly once, for the source tag.
- R2: With the executed flag at 0, the move ends with the destination holding the source's main value. The source is left unchanged and the restore port never pulses.
- R3: A request is accepted on a clock edge where it is valid and busy is low. Counting the cycle after that edge as cycle 1, busy is high from cycle 1 through the done cycle and low in the cycle after it. Done appears in cycle 6 for a swap and in cycle 3 for a copy.
- R4: During a swap, once the source's value has reached the first auxiliary register (from cycle 3 on, or earlier if a write was absorbed), a forwarding read with the source tag returns hit=1 and that register's value. Before that point it returns hit=0, and the register file answers the read.
- R5: During a swap, a forwarding write with the source tag returns hit=1 (the array write must then be suppressed). The source ends the move holding the last such write, including a write made in the final cycle.
- R6: A request presented while busy is high is ignored: it starts no move and writes nothing.
- R7: Done is high for exactly one cycle per move.
- R8: During a copy, forwarding never hits, so writes to the source go to the array as usual.
- R9: After reset, busy, done and the read, restore and write enables are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Move request |
| req_src | input | AW | Source physical register tag |
| req_dst | input | AW | Destination physical register tag |
| req_executed | input | 1 | Source producer already executed (selects swap) |
| busy | output | 1 | Move in flight; new requests are ignored |
| done | output | 1 | One-cycle pulse in the final write cycle |
| rf_rd_en | output | 1 | Register file read request |
| rf_rd_addr | output | AW | Read tag |
| rf_rd_data | input | DW | Read data, one cycle after the request |
| rf_restore_en | output | 1 | Copy shadow cell into main cell |
| rf_restore_addr | output | AW | Restore tag |
| rf_wr_en | output | 1 | Register file write |
| rf_wr_addr | output | AW | Write tag |
| rf_wr_data | output | DW | Write data |
| fw_rd_addr | input | AW | Tag of a read by another instruction |
| fw_rd_hit | output | 1 | Read must use fw_rd_data |
| fw_rd_data | output | DW | Forwarded source value |
| fw_wr_en | input | 1 | Write by another instruction |
| fw_wr_addr | input | AW | Tag of that write |
| fw_wr_data | input | DW | Data of that write |
| fw_wr_hit | output | 1 | Write absorbed; array write must be suppressed |

## Verification
Everything is counted from the edge that accepts a request. The bench samples at falling edges 1, 2, 3 and onward after that edge. It expects done at falling edge 6 for a swap and 3 for a copy, and busy low one edge after done. The forwarding hit flags are combinational, so the bench samples them shortly after it drives the forwarding inputs in a given cycle. Register contents are read from the bench's own register-file model once the move has ended, which makes the two final writes visible one edge after done.

// File: rtl/ckpt_move_pkg.sv
package ckpt_move_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PARK   = 3'd1,  // read source main cell
    ST_GRAB   = 3'd2,  // capture parked value, restore checkpoint
    ST_FETCH  = 3'd3,  // read restored checkpoint
    ST_HOLD   = 3'd4,  // capture checkpoint
    ST_PUTDST = 3'd5,  // write destination
    ST_PUTSRC = 3'd6   // write parked value back to source
  } mv_state_e;

  typedef enum logic {
    SEL_PARKED = 1'b0,
    SEL_CKPT   = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/ckpt_move_ctrl.sv
module ckpt_move_ctrl
  import ckpt_move_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic          req_executed,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          swap_mode,
  output logic          grab_step,
  output logic          hold_step,
  output logic [AW-1:0] src_tag,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          restore_en,
  output logic [AW-1:0] restore_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output wr_sel_e       wr_sel
);
  mv_state_e     state_q, state_d;
  logic [AW-1:0] src_q, dst_q;
  logic          exec_q;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_PARK;
      ST_PARK:   state_d = ST_GRAB;
      ST_GRAB:   state_d = exec_q ? ST_FETCH : ST_PUTDST;
      ST_FETCH:  state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_PUTDST;
      ST_PUTDST: state_d = exec_q ? ST_PUTSRC : ST_IDLE;
      ST_PUTSRC: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      exec_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        src_q  <= req_src;
        dst_q  <= req_dst;
        exec_q <= req_executed;
      end
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign swap_mode    = busy && exec_q;
  assign grab_step    = (state_q == ST_GRAB);
  assign hold_step    = (state_q == ST_HOLD);
  assign src_tag      = src_q;
  assign rd_en        = (state_q == ST_PARK) || (state_q == ST_FETCH);
  assign rd_addr      = src_q;
  assign restore_en   = (state_q == ST_GRAB) && exec_q;
  assign restore_addr = src_q;
  assign wr_en        = (state_q == ST_PUTDST) || (state_q == ST_PUTSRC);
  assign wr_addr      = (state_q == ST_PUTSRC) ? src_q : dst_q;
  assign wr_sel       = ((state_q == ST_PUTDST) && exec_q) ? SEL_CKPT : SEL_PARKED;
  assign done         = ((state_q == ST_PUTDST) && !exec_q) || (state_q == ST_PUTSRC);
endmodule

// File: rtl/ckpt_move_aux.sv
module ckpt_move_aux #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          grab_step,
  input  logic          hold_step,
  input  logic [DW-1:0] rd_data,
  input  logic          absorb,
  input  logic [DW-1:0] absorb_data,
  output logic [DW-1:0] parked,
  output logic [DW-1:0] ckpt,
  output logic          parked_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      parked       <= '0;
      ckpt         <= '0;
      parked_valid <= 1'b0;
    end else begin
      if (start) begin
        parked_valid <= 1'b0;
      end else if (absorb) begin
        parked       <= absorb_data;
        parked_valid <= 1'b1;
      end else if (grab_step && !parked_valid) begin
        parked       <= rd_data;
        parked_valid <= 1'b1;
      end
      if (hold_step) ckpt <= rd_data;
    end
  end
endmodule

// File: rtl/ckpt_move_fwd.sv
module ckpt_move_fwd #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          swap_mode,
  input  logic [AW-1:0] src_tag,
  input  logic          parked_valid,
  input  logic [DW-1:0] parked,
  input  logic [AW-1:0] fw_rd_addr,
  input  logic          fw_wr_en,
  input  logic [AW-1:0] fw_wr_addr,
  output logic          fw_rd_hit,
  output logic [DW-1:0] fw_rd_data,
  output logic          fw_wr_hit
);
  assign fw_rd_hit  = swap_mode && parked_valid && (fw_rd_addr == src_tag);
  assign fw_rd_data = parked;
  assign fw_wr_hit  = swap_mode && fw_wr_en && (fw_wr_addr == src_tag);
endmodule

// File: rtl/ckpt_move_seq.sv
module ckpt_move_seq
  import ckpt_move_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic          req_executed,
  output logic          busy,
  output logic          done,
  output logic          rf_rd_en,
  output logic [AW-1:0] rf_rd_addr,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_restore_en,
  output logic [AW-1:0] rf_restore_addr,
  output logic          rf_wr_en,
  output logic [AW-1:0] rf_wr_addr,
  output logic [DW-1:0] rf_wr_data,
  input  logic [AW-1:0] fw_rd_addr,
  output logic          fw_rd_hit,
  output logic [DW-1:0] fw_rd_data,
  input  logic          fw_wr_en,
  input  logic [AW-1:0] fw_wr_addr,
  input  logic [DW-1:0] fw_wr_data,
  output logic          fw_wr_hit
);
  logic          accept, swap_mode, grab_step, hold_step, parked_valid;
  logic [AW-1:0] src_tag;
  logic [DW-1:0] parked, ckpt;
  wr_sel_e       wr_sel;

  ckpt_move_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .req_executed(req_executed),
    .accept(accept), .busy(busy), .done(done), .swap_mode(swap_mode),
    .grab_step(grab_step), .hold_step(hold_step), .src_tag(src_tag),
    .rd_en(rf_rd_en), .rd_addr(rf_rd_addr),
    .restore_en(rf_restore_en), .restore_addr(rf_restore_addr),
    .wr_en(rf_wr_en), .wr_addr(rf_wr_addr), .wr_sel(wr_sel)
  );

  ckpt_move_aux #(.DW(DW)) u_aux (
    .clk(clk), .rst(rst), .start(accept),
    .grab_step(grab_step), .hold_step(hold_step), .rd_data(rf_rd_data),
    .absorb(fw_wr_hit), .absorb_data(fw_wr_data),
    .parked(parked), .ckpt(ckpt), .parked_valid(parked_valid)
  );

  ckpt_move_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .swap_mode(swap_mode), .src_tag(src_tag),
    .parked_valid(parked_valid), .parked(parked),
    .fw_rd_addr(fw_rd_addr), .fw_wr_en(fw_wr_en), .fw_wr_addr(fw_wr_addr),
    .fw_rd_hit(fw_rd_hit), .fw_rd_data(fw_rd_data), .fw_wr_hit(fw_wr_hit)
  );

  // A write absorbed in the final cycle bypasses straight into the write-back.
  always_comb begin
    if (wr_sel == SEL_CKPT)  rf_wr_data = ckpt;
    else if (fw_wr_hit)      rf_wr_data = fw_wr_data;
    else                     rf_wr_data = parked;
  end
endmodule

// File: rtl/ckpt_move_chk.sv
module ckpt_move_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic rf_rd_en,
  input logic rf_restore_en,
  input logic rf_wr_en,
  input logic fw_rd_hit,
  input logic fw_wr_hit
);
  p_accept_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_in_move_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  p_restore_single_r1: assert property (@(posedge clk) disable iff (rst)
    rf_restore_en |=> !rf_restore_en);
  p_restore_in_move_r2: assert property (@(posedge clk) disable iff (rst)
    rf_restore_en |-> busy);
  p_rd_hit_in_move_r4: assert property (@(posedge clk) disable iff (rst)
    fw_rd_hit |-> busy);
  p_wr_hit_in_move_r5: assert property (@(posedge clk) disable iff (rst)
    fw_wr_hit |-> busy);
  p_ports_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !rf_rd_en);
endmodule

bind ckpt_move_seq ckpt_move_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .rf_rd_en(rf_rd_en), .rf_restore_en(rf_restore_en), .rf_wr_en(rf_wr_en),
  .fw_rd_hit(fw_rd_hit), .fw_wr_hit(fw_wr_hit)
);

// File: tb/sim_ckpt_move_seq.sv
`timescale 1ns/1ps
module sim_ckpt_move_seq;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_executed;
  logic [AW-1:0] req_src, req_dst;
  logic          busy, done;
  logic          rf_rd_en, rf_restore_en, rf_wr_en;
  logic [AW-1:0] rf_rd_addr, rf_restore_addr, rf_wr_addr;
  logic [DW-1:0] rf_rd_data, rf_wr_data;
  logic [AW-1:0] fw_rd_addr, fw_wr_addr;
  logic          fw_rd_hit, fw_wr_en, fw_wr_hit;
  logic [DW-1:0] fw_rd_data, fw_wr_data;

  int checks = 0;
  int errors = 0;
  int restores = 0;

  logic [DW-1:0] main_m [32];
  logic [DW-1:0] shad_m [32];

  always #4 clk = ~clk;

  ckpt_move_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_dst(req_dst), .req_executed(req_executed), .busy(busy), .done(done),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_restore_en(rf_restore_en), .rf_restore_addr(rf_restore_addr),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .fw_rd_addr(fw_rd_addr), .fw_rd_hit(fw_rd_hit), .fw_rd_data(fw_rd_data),
    .fw_wr_en(fw_wr_en), .fw_wr_addr(fw_wr_addr), .fw_wr_data(fw_wr_data),
    .fw_wr_hit(fw_wr_hit)
  );

  // Environment register file: read-before-write, one-cycle read latency.
  always @(posedge clk) begin
    if (rf_rd_en) rf_rd_data <= main_m[rf_rd_addr];
    if (fw_wr_en && !fw_wr_hit) main_m[fw_wr_addr] <= fw_wr_data;
    if (rf_restore_en) begin
      main_m[rf_restore_addr] <= shad_m[rf_restore_addr];
      restores <= restores + 1;
    end
    if (rf_wr_en) main_m[rf_wr_addr] <= rf_wr_data;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one move; k counts falling edges after the accepting edge.
  task automatic do_move(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic ex,
                         input int wr_k, input logic [DW-1:0] wr_v, input int rd_k, input int ign_k,
                         output int done_k, output int busy_bad, output logic busy_after,
                         output logic done_after, output logic rd_hit, output logic [DW-1:0] rd_val,
                         output logic wr_hit);
    done_k = 0; busy_bad = 0; busy_after = 1'b1; done_after = 1'b1;
    rd_hit = 1'b0; rd_val = '0; wr_hit = 1'b0;
    @(negedge clk);
    restores = 0;
    req_valid = 1'b1; req_src = s; req_dst = d; req_executed = ex;
    @(posedge clk);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      req_valid = 1'b0; fw_wr_en = 1'b0; fw_rd_addr = s ^ 5'd1;
      if (done_k == 0 && !busy) busy_bad++;
      if (done_k != 0 && k == done_k + 1) begin
        busy_after = busy;
        done_after = done;
      end
      if (done_k == 0 && done) done_k = k;
      if (k == ign_k) begin
        req_valid = 1'b1; req_src = 5'd21; req_dst = 5'd20; req_executed = 1'b1;
      end
      if (k == rd_k) begin
        fw_rd_addr = s; #1;
        rd_hit = fw_rd_hit; rd_val = fw_rd_data;
      end
      if (k == wr_k) begin
        fw_wr_en = 1'b1; fw_wr_addr = s; fw_wr_data = wr_v; #1;
        wr_hit = fw_wr_hit;
      end
    end
    fw_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check({rf_rd_en, rf_restore_en, rf_wr_en} == 3'b000, "R9 enables",
          {rf_rd_en, rf_restore_en, rf_wr_en}, 0);
  endtask

  task automatic t_swap_basic();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[3] = 32'hA1A1_0003; shad_m[3] = 32'hB1B1_0003; main_m[7] = 32'h0;
    do_move(5'd3, 5'd7, 1'b1, 0, '0, 3, 0, dk, bb, ba, da, rh, rv, wh);
    check(dk == 6, "R3 swap done cycle", dk, 6);
    check(bb == 0, "R3 busy during swap", bb, 0);
    check(ba == 1'b0, "R3 busy low after done", ba, 0);
    check(da == 1'b0, "R7 done one cycle", da, 0);
    check(main_m[7] == 32'hB1B1_0003, "R1 destination gets checkpoint", main_m[7], 32'hB1B1_0003);
    check(main_m[3] == 32'hA1A1_0003, "R1 source keeps main value", main_m[3], 32'hA1A1_0003);
    check(restores == 1, "R1 one restore", restores, 1);
    check(rh == 1'b1 && rv == 32'hA1A1_0003, "R4 read served from parked value", {rh, rv}, {1'b1, 32'hA1A1_0003});
  endtask

  task automatic t_swap_early_read();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[4] = 32'h4444; shad_m[4] = 32'h5555;
    do_move(5'd4, 5'd12, 1'b1, 0, '0, 2, 0, dk, bb, ba, da, rh, rv, wh);
    check(rh == 1'b0, "R4 no hit before parked value", rh, 0);
    check(main_m[12] == 32'h5555, "R1 destination second swap", main_m[12], 32'h5555);
  endtask

  task automatic t_swap_writes();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[5] = 32'h0505; shad_m[5] = 32'h0B0B;
    do_move(5'd5, 5'd13, 1'b1, 4, 32'hC0C0_0004, 0, 0, dk, bb, ba, da, rh, rv, wh);
    check(wh == 1'b1, "R5 write hit mid swap", wh, 1);
    check(main_m[5] == 32'hC0C0_0004, "R5 source holds captured write", main_m[5], 32'hC0C0_0004);
    check(main_m[13] == 32'h0B0B, "R1 destination with write", main_m[13], 32'h0B0B);
    main_m[6] = 32'h0606; shad_m[6] = 32'h0C0C;
    do_move(5'd6, 5'd14, 1'b1, 1, 32'hC2C2, 3, 0, dk, bb, ba, da, rh, rv, wh);
    check(wh == 1'b1, "R5 write hit first cycle", wh, 1);
    check(rh == 1'b1 && rv == 32'hC2C2, "R4 read sees absorbed write", {rh, rv}, {1'b1, 32'hC2C2});
    check(main_m[6] == 32'hC2C2, "R5 early write kept", main_m[6], 32'hC2C2);
    main_m[8] = 32'h0808; shad_m[8] = 32'h0D0D;
    do_move(5'd8, 5'd15, 1'b1, 6, 32'hC3C3, 0, 0, dk, bb, ba, da, rh, rv, wh);
    check(main_m[8] == 32'hC3C3, "R5 final cycle write kept", main_m[8], 32'hC3C3);
    check(main_m[15] == 32'h0D0D, "R1 destination final write case", main_m[15], 32'h0D0D);
  endtask

  task automatic t_copy();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[9] = 32'h0909; shad_m[9] = 32'h9999; main_m[10] = 32'h0;
    do_move(5'd9, 5'd10, 1'b0, 0, '0, 0, 0, dk, bb, ba, da, rh, rv, wh);
    check(dk == 3, "R3 copy done cycle", dk, 3);
    check(ba == 1'b0, "R3 copy busy low after", ba, 0);
    check(main_m[10] == 32'h0909, "R2 destination gets main value", main_m[10], 32'h0909);
    check(main_m[9] == 32'h0909, "R2 source unchanged", main_m[9], 32'h0909);
    check(restores == 0, "R2 no restore", restores, 0);
  endtask

  task automatic t_copy_no_forward();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[11] = 32'h1111; shad_m[11] = 32'h2222;
    do_move(5'd11, 5'd16, 1'b0, 2, 32'h3333, 2, 0, dk, bb, ba, da, rh, rv, wh);
    check(wh == 1'b0, "R8 no write hit in copy", wh, 0);
    check(rh == 1'b0, "R8 no read hit in copy", rh, 0);
    check(main_m[11] == 32'h3333, "R8 write reached array", main_m[11], 32'h3333);
    check(main_m[16] == 32'h1111, "R2 copy took pre-write value", main_m[16], 32'h1111);
  endtask

  task automatic t_busy_ignore();
    int dk, bb; logic ba, da, rh, wh; logic [DW-1:0] rv;
    main_m[17] = 32'h1717; shad_m[17] = 32'h7171;
    main_m[20] = 32'h2020; main_m[21] = 32'h2121; shad_m[21] = 32'h1212;
    do_move(5'd17, 5'd18, 1'b1, 0, '0, 0, 3, dk, bb, ba, da, rh, rv, wh);
    check(dk == 6, "R6 first move timing intact", dk, 6);
    check(ba == 1'b0, "R6 no second move started", ba, 0);
    check(main_m[20] == 32'h2020, "R6 ignored destination untouched", main_m[20], 32'h2020);
    check(main_m[18] == 32'h7171, "R1 destination with ignored request", main_m[18], 32'h7171);
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin main_m[i] = '0; shad_m[i] = '0; end
    rst = 1'b1; req_valid = 1'b0; req_src = '0; req_dst = '0; req_executed = 1'b0;
    fw_rd_addr = '0; fw_wr_en = 1'b0; fw_wr_addr = '0; fw_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_swap_basic();
    t_swap_early_read();
    t_swap_writes();
    t_copy();
    t_copy_no_forward();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule